// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

This block is a general-purpose timer. A counter of configurable width (16 bits by default) runs from a programmable prescaler. It counts up, counts down, or swings between zero and an auto-reload limit (center-aligned). Every wrap or turnaround produces a one-cycle update pulse. A one-pulse option stops the counter at the first update event. The counter stays stopped until the enable input is dropped and raised again. A debug-freeze input holds the prescaler and the counter where they are.

Four independent channels watch the counter. Each channel is configured for one of four jobs:

- capturing the counter value on a rising edge of its capture input,
- toggling its output when the counter reaches its compare value,
- driving active-high PWM,
- driving active-low PWM.

Each channel has an event flag and an overcapture flag. Software-side logic clears both flags with a one-cycle clear pulse.

Top module: `gptim`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count`, `upd`, every channel output, every flag and every capture register read 0.
- R2: With `count_mode` = 0 (up), every counter step adds 1. A step taken at a value >= `arr` loads 0 instead and raises `upd` for exactly the cycle in which 0 first appears.
- R3: With `count_mode` = 1 (down), every step subtracts 1. A step taken at 0 loads `arr` instead and raises `upd` in that same cycle.
- R4: With `count_mode` = 2 or 3 (center), the counter starts rising after reset. It turns at `arr` (next value `arr`-1) and at 0 (next value 1), and raises `upd` in the cycle after each turn.
- R5: The counter steps once every `psc`+1 clock cycles while running.
- R6: While `dbg_freeze` is high, `count` holds its value. Counting resumes from that value once `dbg_freeze` is low.
- R7: With `one_pulse` high, the counter stops at the first update event and stays stopped while `enable` stays high. A low-then-high sequence on `enable` starts it again.
- R8: In capture mode (channel mode 0), a rising edge on the channel's capture input loads the counter value present in that cycle into the channel's capture field and sets its flag. If the flag was already set, the overcapture bit is set as well. A clear pulse resets both.
- R9: In toggle mode (channel mode 1), the channel output inverts one cycle after the counter steps onto the compare value, and the channel flag is set.
- R10: In PWM mode (channel mode 2) the output is high while the previous cycle's count is below the compare value. Mode 3 gives the inverse. A compare of 0 gives 0 % in mode 2, and a compare above `arr` gives 100 % in mode 2.
- R11: Capture-input edges have no effect on a channel that is not in capture mode: its capture field, flag and overcapture bit stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counter enable (level; rising edge re-arms after a one-pulse stop) |
| one_pulse | input | 1 | Stop at the next update event |
| count_mode | input | 2 | 0 up, 1 down, 2/3 center-aligned |
| psc | input | 16 | Prescaler; divide ratio is psc+1 |
| arr | input | 16 | Auto-reload limit |
| dbg_freeze | input | 1 | Holds prescaler and counter |
| ch_mode | input | 8 | Two bits per channel at [2i+1:2i]: 0 capture, 1 toggle, 2 PWM, 3 inverted PWM |
| ch_cmp | input | 64 | Compare value of channel i at [16i+15:16i] |
| cap_in | input | 4 | Capture inputs, synchronous to clk |
| flag_clr | input | 4 | One-cycle clear of a channel's flag and overcapture bit |
| count | output | 16 | Counter value |
| upd | output | 1 | Update event pulse |
| ch_out | output | 4 | Channel outputs |
| ch_flag | output | 4 | Channel event flags |
| ch_ovr | output | 4 | Overcapture flags |
| ch_cap | output | 64 | Captured values, channel i at [16i+15:16i] |

## Verification
The assertions assume two things about the inputs. The capture inputs are already synchronous to the clock. The counter configuration (`count_mode`, `arr`, the channel modes) changes only while the block is in reset or while the checked condition does not apply. The PWM property relies on the channel mode being the same in two consecutive cycles. The center-mode property relies on `arr` being nonzero. The stimulus meets these conditions in three ways:

- It pulses reset before every scenario.
- It sets the whole configuration before enabling the counter.
- It drives every input half a cycle away from the active edge, and changes a compare value only while checks are paused.

// File: rtl/gptim_pkg.sv
package gptim_pkg;
  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_CENTER = 2'd2,
    CM_CENTB  = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    CH_CAPTURE = 2'd0,
    CH_TOGGLE  = 2'd1,
    CH_PWM     = 2'd2,
    CH_PWM_N   = 2'd3
  } ch_mode_e;
endpackage

// File: rtl/gptim_prescaler.sv
module gptim_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc_q;

  assign tick = active && (pc_q >= div);

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (active) pc_q <= (pc_q >= div) ? '0 : pc_q + 1'b1;
  end

  // R5: an idle prescaler never moves
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(pc_q));
endmodule

// File: rtl/gptim_counter.sv
module gptim_counter
  import gptim_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          one_pulse,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] arr,
  input  logic          freeze,
  input  logic          tick,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic          step,
  output logic          upd
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          dir_q, dir_nx;
  logic          wrap;
  logic          en_d, armed_q, step_q, upd_q;

  assign active = armed_q && !freeze;
  assign cnt    = cnt_q;
  assign step   = step_q;
  assign upd    = upd_q;

  always_comb begin
    cnt_nx = cnt_q;
    dir_nx = dir_q;
    wrap   = 1'b0;
    case (cnt_mode_e'(mode))
      CM_UP: begin
        if (cnt_q >= arr) begin
          wrap   = 1'b1;
          cnt_nx = '0;
        end else cnt_nx = cnt_q + 1'b1;
      end
      CM_DOWN: begin
        if (cnt_q == '0) begin
          wrap   = 1'b1;
          cnt_nx = arr;
        end else cnt_nx = cnt_q - 1'b1;
      end
      default: begin
        if (dir_q) begin
          if (cnt_q >= arr) begin
            wrap   = 1'b1;
            dir_nx = 1'b0;
            cnt_nx = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else cnt_nx = cnt_q + 1'b1;
        end else begin
          if (cnt_q == '0) begin
            wrap   = 1'b1;
            dir_nx = 1'b1;
            cnt_nx = (arr == '0) ? '0 : {{(CW-1){1'b0}}, 1'b1};
          end else cnt_nx = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      en_d    <= 1'b0;
      armed_q <= 1'b0;
      step_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      en_d    <= enable;
      armed_q <= enable && (!en_d || (armed_q && !(one_pulse && tick && wrap)));
      step_q  <= tick;
      upd_q   <= tick && wrap;
      if (tick) begin
        cnt_q <= cnt_nx;
        dir_q <= dir_nx;
      end
    end
  end

  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode_e'(mode) == CM_UP && tick && cnt_q < arr) |=> (cnt_q == $past(cnt_q) + 1'b1) && !upd_q);
  p_down_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode_e'(mode) == CM_DOWN && tick && cnt_q == '0) |=> (cnt_q == $past(arr)) && upd_q);
  p_center_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && tick && dir_q && cnt_q >= arr && arr != '0) |=> !dir_q && upd_q);
  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(cnt_q));
  p_opm_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (one_pulse && tick && wrap) |=> !armed_q);
endmodule

// File: rtl/gptim_channel.sv
module gptim_channel
  import gptim_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] cnt,
  input  logic          step,
  input  logic          cap_in,
  input  logic          clr,
  output logic          out,
  output logic          flag,
  output logic          ovr,
  output logic [CW-1:0] cap
);
  logic cap_d, cap_evt, cmp_evt, below;
  logic out_q, flag_q, ovr_q;
  logic [CW-1:0] cap_q;

  assign cap_evt = (ch_mode_e'(mode) == CH_CAPTURE) && cap_in && !cap_d;
  assign cmp_evt = (ch_mode_e'(mode) != CH_CAPTURE) && step && (cnt == cmp);
  assign below   = cnt < cmp;
  assign out  = out_q;
  assign flag = flag_q;
  assign ovr  = ovr_q;
  assign cap  = cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_d  <= 1'b0;
      out_q  <= 1'b0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      cap_d <= cap_in;
      if (cap_evt || cmp_evt) flag_q <= 1'b1;
      else if (clr)           flag_q <= 1'b0;
      if (cap_evt && flag_q)  ovr_q <= 1'b1;
      else if (clr)           ovr_q <= 1'b0;
      if (cap_evt) cap_q <= cnt;
      case (ch_mode_e'(mode))
        CH_TOGGLE: if (cmp_evt) out_q <= !out_q;
        CH_PWM:    out_q <= below;
        CH_PWM_N:  out_q <= !below;
        default:   out_q <= 1'b0;
      endcase
    end
  end

  p_ovr_after_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(flag_q));
  p_pwm_level_r10: assert property (@(posedge clk) disable iff (rst)
    (ch_mode_e'(mode) == CH_PWM && $past(mode) == mode && !$past(rst)) |-> out_q == $past(below));
  p_cap_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (ch_mode_e'(mode) != CH_CAPTURE) |=> $stable(cap_q));
endmodule

// File: rtl/gptim.sv
module gptim
  import gptim_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              one_pulse,
  input  logic [1:0]        count_mode,
  input  logic [PW-1:0]     psc,
  input  logic [CW-1:0]     arr,
  input  logic              dbg_freeze,
  input  logic [2*NCH-1:0]  ch_mode,
  input  logic [CW*NCH-1:0] ch_cmp,
  input  logic [NCH-1:0]    cap_in,
  input  logic [NCH-1:0]    flag_clr,
  output logic [CW-1:0]     count,
  output logic              upd,
  output logic [NCH-1:0]    ch_out,
  output logic [NCH-1:0]    ch_flag,
  output logic [NCH-1:0]    ch_ovr,
  output logic [CW*NCH-1:0] ch_cap
);
  logic active, tick, step;

  gptim_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst(rst), .active(active), .div(psc), .tick(tick)
  );

  gptim_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .one_pulse(one_pulse),
    .mode(count_mode), .arr(arr), .freeze(dbg_freeze), .tick(tick),
    .active(active), .cnt(count), .step(step), .upd(upd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gptim_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .mode(ch_mode[2*i +: 2]),
      .cmp(ch_cmp[CW*i +: CW]), .cnt(count), .step(step),
      .cap_in(cap_in[i]), .clr(flag_clr[i]),
      .out(ch_out[i]), .flag(ch_flag[i]), .ovr(ch_ovr[i]),
      .cap(ch_cap[CW*i +: CW])
    );
  end

  // R1: no output activity while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && !upd && (ch_out == '0) && (ch_flag == '0));
endmodule

// File: tb/gptim_bench.sv
module gptim_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, enable, one_pulse, dbg_freeze;
  logic [1:0]  count_mode;
  logic [15:0] psc, arr;
  logic [7:0]  ch_mode;
  logic [63:0] ch_cmp;
  logic [3:0]  cap_in, flag_clr;
  logic [15:0] count;
  logic        upd;
  logic [3:0]  ch_out, ch_flag, ch_ovr;
  logic [63:0] ch_cap;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gptim u_gptim (
    .clk(clk), .rst(rst), .enable(enable), .one_pulse(one_pulse),
    .count_mode(count_mode), .psc(psc), .arr(arr), .dbg_freeze(dbg_freeze),
    .ch_mode(ch_mode), .ch_cmp(ch_cmp), .cap_in(cap_in), .flag_clr(flag_clr),
    .count(count), .upd(upd), .ch_out(ch_out), .ch_flag(ch_flag),
    .ch_ovr(ch_ovr), .ch_cap(ch_cap)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; one_pulse = 1'b0; dbg_freeze = 1'b0;
    count_mode = 2'd0; psc = '0; arr = 16'd100; ch_mode = '0; ch_cmp = '0;
    cap_in = '0; flag_clr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic start_run();
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(count == 0, "R1 count", count, 0);
    check(upd == 0, "R1 upd", upd, 0);
    check({ch_out, ch_flag, ch_ovr} == 0, "R1 channel bits", {ch_out, ch_flag, ch_ovr}, 0);
    check(ch_cap == 0, "R1 capture", ch_cap, 0);
  endtask

  task automatic t_up();
    do_reset(); arr = 16'd4; count_mode = 2'd0;
    start_run();
    for (int k = 0; k < 14; k++) begin
      int prev, exp;
      prev = count;
      @(negedge clk);
      exp = (prev >= 4) ? 0 : prev + 1;
      check(count == exp, "R2 up count", count, exp);
      check(upd == (prev >= 4), "R2 up update", upd, prev >= 4);
    end
  endtask

  task automatic t_down();
    do_reset(); arr = 16'd3; count_mode = 2'd1;
    start_run();
    for (int k = 0; k < 12; k++) begin
      int prev, exp;
      prev = count;
      @(negedge clk);
      exp = (prev == 0) ? 3 : prev - 1;
      check(count == exp, "R3 down count", count, exp);
      check(upd == (prev == 0), "R3 down update", upd, prev == 0);
    end
  endtask

  task automatic t_center();
    bit up = 1'b1;
    do_reset(); arr = 16'd4; count_mode = 2'd2;
    start_run();
    for (int k = 0; k < 20; k++) begin
      int prev, exp;
      bit turn;
      prev = count; turn = 1'b0;
      if (up) begin
        if (prev >= 4) begin exp = prev - 1; up = 1'b0; turn = 1'b1; end
        else exp = prev + 1;
      end else begin
        if (prev == 0) begin exp = 1; up = 1'b1; turn = 1'b1; end
        else exp = prev - 1;
      end
      @(negedge clk);
      check(count == exp, "R4 center count", count, exp);
      check(upd == turn, "R4 center update", upd, turn);
    end
  endtask

  task automatic t_prescale();
    do_reset(); arr = 16'd1000; psc = 16'd2;
    start_run();
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check(count == k / 3, "R5 prescaled count", count, k / 3);
    end
  endtask

  task automatic t_freeze();
    int held;
    do_reset(); arr = 16'd100;
    start_run();
    repeat (5) @(negedge clk);
    held = count;
    dbg_freeze = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(count == held, "R6 frozen", count, held);
    end
    dbg_freeze = 1'b0;
    @(negedge clk);
    check(count == held + 1, "R6 resume", count, held + 1);
  endtask

  task automatic t_one_pulse();
    int n_upd = 0;
    do_reset(); arr = 16'd3; one_pulse = 1'b1;
    start_run();
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (upd) n_upd++;
    end
    check(n_upd == 1, "R7 single update", n_upd, 1);
    check(count == 0, "R7 stopped value", count, 0);
    enable = 1'b0;
    @(negedge clk);
    start_run();
    @(negedge clk);
    check(count == 1, "R7 restart", count, 1);
  endtask

  task automatic t_capture();
    int snap;
    do_reset(); arr = 16'd1000; ch_mode = 8'b00_00_01_00; ch_cmp[31:16] = 16'd2000;
    start_run();
    repeat (5) @(negedge clk);
    snap = count; cap_in[0] = 1'b1;
    @(negedge clk);
    check(ch_cap[15:0] == snap, "R8 captured value", ch_cap[15:0], snap);
    check(ch_flag[0] == 1, "R8 flag", ch_flag[0], 1);
    check(ch_ovr[0] == 0, "R8 no overcapture", ch_ovr[0], 0);
    cap_in[0] = 1'b0;
    @(negedge clk);
    snap = count; cap_in[0] = 1'b1;
    @(negedge clk);
    check(ch_ovr[0] == 1, "R8 overcapture", ch_ovr[0], 1);
    check(ch_cap[15:0] == snap, "R8 second capture", ch_cap[15:0], snap);
    cap_in[0] = 1'b0; flag_clr[0] = 1'b1;
    @(negedge clk);
    flag_clr[0] = 1'b0;
    check(ch_flag[0] == 0 && ch_ovr[0] == 0, "R8 clear", {ch_flag[0], ch_ovr[0]}, 0);
    cap_in[1] = 1'b1;
    @(negedge clk);
    cap_in[1] = 1'b0;
    @(negedge clk);
    check(ch_cap[31:16] == 0, "R11 capture untouched", ch_cap[31:16], 0);
    check(ch_flag[1] == 0 && ch_ovr[1] == 0, "R11 flags untouched", {ch_flag[1], ch_ovr[1]}, 0);
  endtask

  task automatic t_toggle();
    int n_tog = 0;
    do_reset(); arr = 16'd5; ch_mode = 8'b00_00_01_00; ch_cmp[31:16] = 16'd2;
    start_run();
    for (int k = 0; k < 12; k++) begin
      int prev;
      bit prev_out;
      prev = count; prev_out = ch_out[1];
      @(negedge clk);
      if (ch_out[1] != prev_out) n_tog++;
      check((ch_out[1] != prev_out) == (prev == 2), "R9 toggle timing", ch_out[1], prev_out ^ (prev == 2));
    end
    check(n_tog == 2, "R9 toggle count", n_tog, 2);
    check(ch_flag[1] == 1, "R9 compare flag", ch_flag[1], 1);
  endtask

  task automatic t_pwm();
    do_reset(); arr = 16'd7; ch_mode = 8'b11_10_00_00;
    ch_cmp[47:32] = 16'd3; ch_cmp[63:48] = 16'd3;
    start_run();
    for (int k = 0; k < 16; k++) begin
      int prev;
      prev = count;
      @(negedge clk);
      check(ch_out[2] == (prev < 3), "R10 pwm high", ch_out[2], prev < 3);
      check(ch_out[3] == (prev >= 3), "R10 pwm low", ch_out[3], prev >= 3);
    end
    ch_cmp[47:32] = 16'd0; ch_cmp[63:48] = 16'd8;
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      check(ch_out[2] == 0, "R10 zero duty", ch_out[2], 0);
      check(ch_out[3] == 0, "R10 inverted full", ch_out[3], 0);
    end
    ch_cmp[47:32] = 16'd8;
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      check(ch_out[2] == 1, "R10 full duty", ch_out[2], 1);
    end
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; one_pulse = 1'b0; dbg_freeze = 1'b0;
    count_mode = '0; psc = '0; arr = '0; ch_mode = '0; ch_cmp = '0;
    cap_in = '0; flag_clr = '0;
    t_reset();
    t_up();
    t_down();
    t_center();
    t_prescale();
    t_freeze();
    t_one_pulse();
    t_capture();
    t_toggle();
    t_pwm();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule